// File: doc/BRIEF.md
# SONET Frame Detector with Lane Roll

This block watches one deinterleaved lane of a bit-interleaved serial link, delivered as a stream of single bits qualified by a valid strobe. It looks for the 32-bit framing word made of two A1 bytes followed by two A2 bytes. When it finds the word it checks that the same word returns exactly one frame length later. When the word keeps returning at that spacing it reports that the lane is framed by raising `sync_ok`.

While it is hunting, a cycle timer runs. If no framing word turns up before the timer expires, the block sends a one-cycle `roll` strobe so that the upstream deinterleaver rotates its lane assignment, and the hunt goes on with a fresh timer. Once framed, the block tolerates a few corrupted framing words. After a set number of misses in a row it drops back to hunting. A byte index within the frame, counted from the end of the last accepted framing word, is provided for downstream overhead logic.

The frame length in bits, the timeout in clock cycles, the number of misses tolerated and the two marker bytes are parameters. Small values keep simulation short.

Top module: `sonet_frame_sync`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to hunting, and after that edge `sync_ok` is 0, `roll` is 0 and `byte_pos` is 0.
- R2: The framing word is {MARK_A, MARK_A, MARK_B, MARK_B} (default 0xF6F62828), compared MSB-first against the last 32 valid bits, with the most recent bit as the LSB. In the hunt state, a match moves the block to the confirm state and sets the bit position to 0, so `byte_pos` reads 0 after that edge.
- R3: Each valid bit advances the bit position by one, modulo FRAME_BITS. `byte_pos` equals the bit position divided by 8. A cycle with `bit_vld` low changes neither `byte_pos` nor `sync_ok`.
- R4: In the confirm state, only a match whose last bit is exactly FRAME_BITS valid bits after the first match counts. That match raises `sync_ok` at the same clock edge. Matches at any other position are ignored.
- R5: In the confirm state, if the framing word is absent at the expected position, the block returns to hunting with `sync_ok` low, and it needs two new matches one frame apart to lock again.
- R6: In the hunt state, when TIMEOUT clock cycles pass without a match, `roll` is high for exactly one cycle and the timer restarts. The timer also starts from zero on reset and whenever the hunt state is re-entered. After reset, the first roll appears after the TIMEOUT-th edge.
- R7: While framed, the block checks every expected position. `sync_ok` falls at the edge of the MISS_LIMIT-th consecutive miss (default 4). A match at an expected position clears the miss count.
- R8: `roll` is never high outside the hunt state. In particular, it stays low while confirming and while framed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane bit clock |
| rst | input | 1 | Synchronous active-high frame reset, which forces the hunt state |
| bit_in | input | 1 | Lane data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| roll | output | 1 | One-cycle request for the deinterleaver to rotate its lanes |
| sync_ok | output | 1 | High while framed, low while hunting or confirming |
| byte_pos | output | $clog2(FRAME_BITS)-3 | Byte index since the last accepted framing word |

## Verification
The assertions assume a few things about the inputs. TIMEOUT must be at least two cycles, so that roll strobes can never touch. FRAME_BITS must be a multiple of eight, so that the byte index is meaningful. A framing word can only be seen on a valid bit, so an idle cycle must never move the position. The stimulus is built to match these assumptions and the design's expectations. It inserts framing words only where the bench intends them, and it flips any random payload bit that would complete a framing word by accident. The default marker word has no self-overlap, so it cannot match early against its own prefix. Random idle cycles are sparse enough that a hunt lasting one or two frames stays well inside the timeout. This keeps unplanned roll strobes out of the locking scenarios.

// File: rtl/sfd_pkg.sv
`timescale 1ns/1ps
package sfd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sfd_state_e;

  localparam int MARK_W = 8;
  localparam int WORD_W = 4 * MARK_W;
endpackage

// File: rtl/sfd_matcher.sv
`timescale 1ns/1ps
module sfd_matcher #(
  parameter logic [sfd_pkg::MARK_W-1:0] MARK_A = 8'hF6,
  parameter logic [sfd_pkg::MARK_W-1:0] MARK_B = 8'h28
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic hit
);
  localparam int WW = sfd_pkg::WORD_W;
  localparam logic [WW-1:0] WORD = {MARK_A, MARK_A, MARK_B, MARK_B};

  logic [WW-1:0] win_q;
  logic [WW-1:0] win_nx;

  // newest bit enters at the LSB, so the first bit received ends up at the MSB
  assign win_nx = {win_q[WW-2:0], bit_in};
  assign hit    = bit_vld && (win_nx == WORD);

  always_ff @(posedge clk) begin
    if (rst)          win_q <= '0;
    else if (bit_vld) win_q <= win_nx;
  end

  // R3
  idle_window_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(win_q));
endmodule

// File: rtl/sfd_position.sv
`timescale 1ns/1ps
module sfd_position #(
  parameter int FRAME_BITS = 77760,
  parameter int PW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_vld,
  input  logic          load,
  output logic          at_mark,
  output logic [PW-4:0] byte_idx
);
  localparam logic [PW-1:0] P_LAST = PW'(FRAME_BITS - 1);

  logic [PW-1:0] pos_q;

  assign at_mark  = bit_vld && (pos_q == P_LAST);
  assign byte_idx = pos_q[PW-1:3];

  always_ff @(posedge clk) begin
    if (rst)            pos_q <= '0;
    else if (load)      pos_q <= '0;
    else if (at_mark)   pos_q <= '0;
    else if (bit_vld)   pos_q <= pos_q + PW'(1);
  end

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= P_LAST);

  // R3
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(pos_q));
endmodule

// File: rtl/sfd_ctrl.sv
`timescale 1ns/1ps
module sfd_ctrl
  import sfd_pkg::*;
#(
  parameter int TIMEOUT    = 155520,
  parameter int MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic at_mark,
  output logic load,
  output logic roll,
  output logic sync_ok
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [TW-1:0] T_END = TW'(TIMEOUT - 1);
  localparam logic [MW-1:0] M_END = MW'(MISS_LIMIT - 1);

  sfd_state_e    state_q, state_nx;
  logic [TW-1:0] timer_q, timer_nx;
  logic [MW-1:0] miss_q, miss_nx;
  logic          roll_q, roll_nx;
  logic          sync_q;

  always_comb begin
    state_nx = state_q;
    timer_nx = timer_q;
    miss_nx  = miss_q;
    roll_nx  = 1'b0;
    load     = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (hit) begin
          state_nx = ST_VERIFY;
          load     = 1'b1;
          timer_nx = '0;
        end else if (timer_q == T_END) begin
          roll_nx  = 1'b1;
          timer_nx = '0;
        end else begin
          timer_nx = timer_q + TW'(1);
        end
      end
      ST_VERIFY: begin
        if (at_mark) begin
          if (hit) begin
            state_nx = ST_LOCKED;
            miss_nx  = '0;
          end else begin
            state_nx = ST_HUNT;
            timer_nx = '0;
          end
        end
      end
      ST_LOCKED: begin
        if (at_mark) begin
          if (hit) begin
            miss_nx = '0;
          end else if (miss_q == M_END) begin
            state_nx = ST_HUNT;
            timer_nx = '0;
            miss_nx  = '0;
          end else begin
            miss_nx = miss_q + MW'(1);
          end
        end
      end
      default: begin
        state_nx = ST_HUNT;
        timer_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      timer_q <= '0;
      miss_q  <= '0;
      roll_q  <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      timer_q <= timer_nx;
      miss_q  <= miss_nx;
      roll_q  <= roll_nx;
      sync_q  <= (state_nx == ST_LOCKED);
    end
  end

  assign roll    = roll_q;
  assign sync_ok = sync_q;

  // R6
  roll_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    roll_q |=> !roll_q);

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    timer_q <= T_END);

  // R8
  roll_hunt_chk: assert property (@(posedge clk) disable iff (rst)
    roll_q |-> state_q == ST_HUNT);

  // R4
  lock_at_mark_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_q) |-> $past(at_mark && hit));

  // R7
  drop_at_mark_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_q) |-> ($past(rst) || $past(at_mark && !hit)));

  // R7
  miss_bound_chk: assert property (@(posedge clk) disable iff (rst)
    miss_q <= M_END);
endmodule

// File: rtl/sonet_frame_sync.sv
`timescale 1ns/1ps
module sonet_frame_sync #(
  parameter int          FRAME_BITS = 77760,
  parameter int          TIMEOUT    = 2 * FRAME_BITS,
  parameter int          MISS_LIMIT = 4,
  parameter logic [7:0]  MARK_A     = 8'hF6,
  parameter logic [7:0]  MARK_B     = 8'h28
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bit_in,
  input  logic                            bit_vld,
  output logic                            roll,
  output logic                            sync_ok,
  output logic [$clog2(FRAME_BITS)-4:0]   byte_pos
);
  localparam int PW = $clog2(FRAME_BITS);

  logic hit;
  logic at_mark;
  logic load;

  sfd_matcher #(
    .MARK_A (MARK_A),
    .MARK_B (MARK_B)
  ) u_match (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .hit     (hit)
  );

  sfd_position #(
    .FRAME_BITS (FRAME_BITS),
    .PW         (PW)
  ) u_pos (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .load     (load),
    .at_mark  (at_mark),
    .byte_idx (byte_pos)
  );

  sfd_ctrl #(
    .TIMEOUT    (TIMEOUT),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .at_mark (at_mark),
    .load    (load),
    .roll    (roll),
    .sync_ok (sync_ok)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sync_ok && !roll));
endmodule

// File: tb/sonet_frame_sync_bench.sv
`timescale 1ns/1ps
module sonet_frame_sync_bench;
  localparam int FB = 64;
  localparam int TO = 200;
  localparam int ML = 4;
  localparam logic [31:0] WORD = 32'hF6F62828;

  logic       clk = 1'b0;
  logic       rst;
  logic       bit_in;
  logic       bit_vld;
  logic       roll;
  logic       sync_ok;
  logic [2:0] byte_pos;

  int   nchk = 0;
  int   nfail = 0;
  int   rolls = 0;
  bit   done = 1'b0;
  bit   gaps_on = 1'b0;
  bit   rst_drv = 1'b1;
  logic [31:0] bw = '0;

  always #10 clk = ~clk;

  sonet_frame_sync #(
    .FRAME_BITS (FB),
    .TIMEOUT    (TO),
    .MISS_LIMIT (ML)
  ) u_sonet_frame_sync (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (bit_in),
    .bit_vld  (bit_vld),
    .roll     (roll),
    .sync_ok  (sync_ok),
    .byte_pos (byte_pos)
  );

  function automatic int exp_byte(input int nbits);
    return nbits / 8;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic v);
    @(negedge clk);
    rst     = rst_drv;
    bit_in  = b;
    bit_vld = v;
    @(posedge clk);
    #2;
    if (roll) rolls++;
    if (v && !rst_drv) bw = {bw[30:0], b};
  endtask

  task automatic send_bit(input logic b);
    if (gaps_on && ($urandom % 5 == 0)) step(1'($urandom & 1), 1'b0);
    step(b, 1'b1);
  endtask

  task automatic send_pay(input int n);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = 1'($urandom & 1);
      if ({bw[30:0], b} == WORD) b = ~b;
      send_bit(b);
    end
  endtask

  task automatic send_part(input bit bad, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(WORD[i] ^ (bad && i == 0));
  endtask

  task automatic send_word(input bit bad);
    send_part(bad, 31, 0);
  endtask

  task automatic do_reset();
    rst_drv = 1'b1;
    repeat (3) step(1'b0, 1'b0);
    rst_drv = 1'b0;
    bw      = '0;
    rolls   = 0;
  endtask

  initial begin
    int seen;
    int r_a;
    int r_b;
    int r0;
    int n;
    void'($urandom(32'd4242));
    rst = 1'b1; bit_in = 1'b0; bit_vld = 1'b0;

    // reset state
    do_reset();
    chk("R1 sync_ok after reset", sync_ok, 0);
    chk("R1 roll after reset", roll, 0);
    chk("R1 byte_pos after reset", byte_pos, 0);

    // timeout rolls while hunting on random data
    gaps_on = 1'b0;
    seen = 0; r_a = -1; r_b = -1;
    for (int k = 1; k <= 2 * TO + 3; k++) begin
      send_pay(1);
      if (roll) begin
        if (seen == 0) r_a = k;
        else if (seen == 1) r_b = k;
        seen++;
      end
    end
    chk("R6 roll count over two timeouts", seen, 2);
    chk("R6 first roll cycle", r_a, TO);
    chk("R6 second roll cycle", r_b, 2 * TO);

    // first hit, then confirm one frame later
    gaps_on = 1'b1;
    send_word(1'b0);
    r0 = rolls;
    chk("R2 sync_ok low after first word", sync_ok, 0);
    chk("R2 byte_pos cleared on first word", byte_pos, 0);
    send_pay(20);
    chk("R3 byte_pos after 20 bits", byte_pos, exp_byte(20));
    repeat (5) step(1'($urandom & 1), 1'b0);
    chk("R3 byte_pos held over idle cycles", byte_pos, exp_byte(20));
    chk("R3 sync_ok held over idle cycles", sync_ok, 0);
    send_pay(12);
    send_part(1'b0, 31, 1);
    chk("R4 sync_ok low before last bit", sync_ok, 0);
    send_part(1'b0, 0, 0);
    chk("R4 sync_ok high after confirm", sync_ok, 1);

    // framed: random split frames check the byte index
    for (int f = 0; f < 6; f++) begin
      n = int'($urandom % 33);
      send_pay(n);
      chk("R3 byte_pos inside frame", byte_pos, exp_byte(n));
      send_pay(32 - n);
      send_word(1'b0);
      chk("R7 stays framed on good word", sync_ok, 1);
      chk("R3 byte_pos at word end", byte_pos, 0);
    end

    // three misses then a hit: miss count clears
    for (int f = 0; f < 3; f++) begin
      send_pay(32); send_word(1'b1);
      chk("R7 framed after tolerated miss", sync_ok, 1);
    end
    send_pay(32); send_word(1'b0);
    chk("R7 framed after recovering hit", sync_ok, 1);
    for (int f = 0; f < 3; f++) begin
      send_pay(32); send_word(1'b1);
      chk("R7 framed after miss following clear", sync_ok, 1);
    end
    send_pay(32); send_word(1'b0);
    chk("R7 framed after second recovery", sync_ok, 1);
    for (int f = 0; f < ML - 1; f++) begin
      send_pay(32); send_word(1'b1);
      chk("R7 framed before miss limit", sync_ok, 1);
    end
    chk("R8 no roll while confirming or framed", rolls, r0);
    send_pay(32); send_word(1'b1);
    chk("R7 frame lost at miss limit", sync_ok, 0);

    // failed confirmation returns to hunting
    send_pay(32); send_word(1'b0);
    chk("R5 first word after loss", sync_ok, 0);
    send_pay(32); send_word(1'b1);
    chk("R5 confirm miss keeps sync low", sync_ok, 0);
    send_pay(32); send_word(1'b0);
    chk("R5 new first word needs confirm", sync_ok, 0);
    send_pay(32); send_word(1'b0);
    chk("R5 relock after two new words", sync_ok, 1);

    // misplaced word while confirming is ignored
    do_reset();
    send_word(1'b0);
    send_word(1'b0);
    chk("R4 misplaced word does not lock", sync_ok, 0);
    send_word(1'b0);
    chk("R4 lock at frame spacing despite misplaced word", sync_ok, 1);

    // reset while framed, then timer restarts
    do_reset();
    chk("R1 reset drops sync_ok", sync_ok, 0);
    gaps_on = 1'b0;
    seen = 0; r_a = -1;
    for (int k = 1; k <= TO + 2; k++) begin
      send_pay(1);
      if (roll) begin
        if (seen == 0) r_a = k;
        seen++;
      end
    end
    chk("R6 roll count after reset", seen, 1);
    chk("R6 roll cycle after reset", r_a, TO);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R1-run actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule